// File: doc/BRIEF.md
# DDR Output Lane Interleaver

This block takes one sample per sample period and drives it toward the output pads in one of two forms. In the parallel mode the whole word appears on all lanes at once and is held for the full period. In the double-data-rate mode only the lower half of the lanes is used, and each lane carries two bits of the sample, one per half period. Two pairings of bits to lanes are available. The even/odd order puts bit 2k and bit 2k+1 on lane k. The split-word order puts bit k in the first half and bit k+W/2 in the second half.

The design is fully synchronous to a clock running at twice the sample rate, so every sample period has a first and a second half. A forwarded output clock is high while first-half data is on the lanes and can be inverted, which lets the receiver pick its capture edge. A data-position control delays every data transition by one half period while leaving the clock where it is. Two enables are provided for the pad drivers. One disables both data and clock. The other disables only the clock.

All configuration inputs except the two buffer controls are taken at sample boundaries only. Because of this, one sample is never split across two orderings.

Top module: `ddr_lane_interleaver`

## Requirements
- R1: While `rst` is high, and at the first clock edge after it is released, `lane_out` is 0, `clk_out` is 0, and `data_oe` and `clk_oe` are both 1.
- R2: Counting edges from 0 at the first edge with `rst` low, the even edges are sample boundaries. `sample_in` is captured only on those edges, and its value at odd edges has no effect. With the default data position, the first half of a sample captured at edge t is visible after edge t+2 and its second half after edge t+3.
- R3: When `lvds_mode`=1 and `byte_order`=0 (even/odd order), lane k (k < W/2) carries sample bit 2k in the first half and bit 2k+1 in the second half. Lanes W/2 and above are 0.
- R4: When `lvds_mode`=1 and `byte_order`=1 (split-word order), lane k carries sample bit k in the first half and bit k+W/2 in the second half. Lanes W/2 and above are 0.
- R5: When `lvds_mode`=0 (parallel mode), `lane_out` equals the whole sample in both halves, and `byte_order` has no effect.
- R6: When `data_delay`=1 for a sample, each half of that sample reaches `lane_out` one edge later than it would with the default position.
- R7: `clk_out` is 1 after even edges and 0 after odd edges, XOR the `clk_invert` value taken at the most recent boundary. At an even edge, the new value of `clk_invert` is used.
- R8: One edge after the inputs are sampled, `data_oe` equals NOT `obuf_off`, and `clk_oe` equals NOT (`obuf_off` OR `clkbuf_off`).
- R9: `lvds_mode`, `byte_order`, `data_delay` and `clk_invert` are taken only at boundary edges. Changes applied at odd edges do not alter the sample that is in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at twice the sample rate |
| rst | input | 1 | Synchronous active-high reset |
| sample_in | input | W | Sample word, captured at boundary edges |
| lvds_mode | input | 1 | 1 selects double-data-rate lanes, 0 selects the parallel mode |
| byte_order | input | 1 | 1 selects split-word order, 0 selects even/odd order |
| data_delay | input | 1 | 1 delays data transitions by a half period |
| clk_invert | input | 1 | 1 inverts the forwarded clock |
| obuf_off | input | 1 | Disables the data and clock drivers |
| clkbuf_off | input | 1 | Disables only the clock driver |
| lane_out | output | W | Lane data toward the pads |
| clk_out | output | 1 | Forwarded output clock |
| data_oe | output | 1 | Enable for the data pad drivers |
| clk_oe | output | 1 | Enable for the clock pad driver |

## Verification
A change of ordering and a change of data position can land on the same boundary edge. When that happens, the half that leaves the delay stage still belongs to the old sample, while the newly captured sample takes the new pairing. To provoke this, the bench draws all four configuration bits at random on every edge, odd edges included. A behavioural model keeps a record of produced halves per edge, each tagged with its sample's delay flag, and the outputs are compared against it on every clock. A repeated or dropped half at a switch is therefore judged exactly, not masked.

// File: rtl/ddr_lane_pkg.sv
package ddr_lane_pkg;
  typedef struct packed {
    logic lvds;
    logic byte_ord;
    logic dly;
    logic inv;
  } lane_cfg_t;
endpackage

// File: rtl/ddr_lane_capture.sv
module ddr_lane_capture
  import ddr_lane_pkg::*;
#(
  parameter int W = 12
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [W-1:0]    sample_in,
  input  lane_cfg_t       cfg_in,
  output logic            bound,
  output logic [W-1:0]    cap_q,
  output lane_cfg_t       cfg_q
);
  logic half_q;

  // half_q == 0 marks the edge that opens a new sample period
  assign bound = ~half_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      half_q <= 1'b0;
      cap_q  <= '0;
      cfg_q  <= '0;
    end else begin
      half_q <= ~half_q;
      if (bound) begin
        cap_q <= sample_in;
        cfg_q <= cfg_in;
      end
    end
  end

  AST_CAP_HOLD: assert property (@(posedge clk) disable iff (rst)
    !bound |=> $stable(cap_q)); // R2

  AST_CFG_HOLD: assert property (@(posedge clk) disable iff (rst)
    !bound |=> $stable(cfg_q)); // R9
endmodule

// File: rtl/ddr_lane_mux.sv
module ddr_lane_mux
  import ddr_lane_pkg::*;
#(
  parameter int W = 12
) (
  input  logic [W-1:0] cap,
  input  lane_cfg_t    cfg,
  input  logic         second,
  output logic [W-1:0] pre
);
  localparam int LANES = W / 2;

  logic [LANES-1:0] ddr_w;

  genvar k;
  generate
    for (k = 0; k < LANES; k++) begin : g_lane
      logic lo_bit;
      logic hi_bit;
      assign lo_bit   = cfg.byte_ord ? cap[k]         : cap[2*k];
      assign hi_bit   = cfg.byte_ord ? cap[k + LANES] : cap[2*k + 1];
      assign ddr_w[k] = second ? hi_bit : lo_bit;
    end
  endgenerate

  assign pre = cfg.lvds ? {{(W - LANES){1'b0}}, ddr_w} : cap;

  always_comb begin
    if (cfg.lvds) begin
      AST_UPPER_IDLE: assert (pre[W-1:LANES] == '0); // R3
    end
  end
endmodule

// File: rtl/ddr_lane_out.sv
module ddr_lane_out #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] pre,
  input  logic         pre_dly,
  input  logic         bound,
  input  logic         inv_in,
  input  logic         inv_q,
  input  logic         obuf_off,
  input  logic         clkbuf_off,
  output logic [W-1:0] lane_out,
  output logic         clk_out,
  output logic         data_oe,
  output logic         clk_oe
);
  logic [W-1:0] lane_a_q;
  logic [W-1:0] lane_b_q;
  logic         a_dly_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      lane_a_q <= '0;
      lane_b_q <= '0;
      a_dly_q  <= 1'b0;
      lane_out <= '0;
      clk_out  <= 1'b0;
      data_oe  <= 1'b1;
      clk_oe   <= 1'b1;
    end else begin
      lane_a_q <= pre;
      a_dly_q  <= pre_dly;
      lane_b_q <= lane_a_q;
      lane_out <= a_dly_q ? lane_b_q : lane_a_q;
      clk_out  <= bound ? ~inv_in : inv_q;
      data_oe  <= ~obuf_off;
      clk_oe   <= ~(obuf_off | clkbuf_off);
    end
  end

  AST_CLK_OFF: assert property (@(posedge clk) disable iff (rst)
    !data_oe |-> !clk_oe); // R8

  AST_DLY_SHIFT: assert property (@(posedge clk) disable iff (rst)
    (a_dly_q && !$past(rst)) |=> (lane_out == $past(lane_b_q))); // R6
endmodule

// File: rtl/ddr_lane_interleaver.sv
module ddr_lane_interleaver
  import ddr_lane_pkg::*;
#(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] sample_in,
  input  logic         lvds_mode,
  input  logic         byte_order,
  input  logic         data_delay,
  input  logic         clk_invert,
  input  logic         obuf_off,
  input  logic         clkbuf_off,
  output logic [W-1:0] lane_out,
  output logic         clk_out,
  output logic         data_oe,
  output logic         clk_oe
);
  lane_cfg_t    cfg_in;
  lane_cfg_t    cfg_q;
  logic         bound;
  logic [W-1:0] cap_q;
  logic [W-1:0] pre;

  assign cfg_in = '{lvds: lvds_mode, byte_ord: byte_order,
                    dly: data_delay, inv: clk_invert};

  ddr_lane_capture #(.W(W)) u_cap (
    .clk(clk), .rst(rst), .sample_in(sample_in), .cfg_in(cfg_in),
    .bound(bound), .cap_q(cap_q), .cfg_q(cfg_q)
  );

  ddr_lane_mux #(.W(W)) u_mux (
    .cap(cap_q), .cfg(cfg_q), .second(bound), .pre(pre)
  );

  ddr_lane_out #(.W(W)) u_out (
    .clk(clk), .rst(rst), .pre(pre), .pre_dly(cfg_q.dly), .bound(bound),
    .inv_in(clk_invert), .inv_q(cfg_q.inv), .obuf_off(obuf_off),
    .clkbuf_off(clkbuf_off), .lane_out(lane_out), .clk_out(clk_out),
    .data_oe(data_oe), .clk_oe(clk_oe)
  );
endmodule

// File: tb/ddr_lane_interleaver_tb_top.sv
module ddr_lane_interleaver_tb_top;
  localparam int W = 12;
  localparam int H = W / 2;

  logic         clk = 1'b0;
  logic         rst;
  logic [W-1:0] sample_in;
  logic         lvds_mode, byte_order, data_delay, clk_invert;
  logic         obuf_off, clkbuf_off;
  logic [W-1:0] lane_out;
  logic         clk_out, data_oe, clk_oe;

  ddr_lane_interleaver #(.W(W)) dut_i (
    .clk(clk), .rst(rst), .sample_in(sample_in), .lvds_mode(lvds_mode),
    .byte_order(byte_order), .data_delay(data_delay), .clk_invert(clk_invert),
    .obuf_off(obuf_off), .clkbuf_off(clkbuf_off), .lane_out(lane_out),
    .clk_out(clk_out), .data_oe(data_oe), .clk_oe(clk_oe)
  );

  always #10 clk = ~clk;

  int total = 0;
  int bad   = 0;

  // model state: halves produced per edge, with their delay flag
  logic [W-1:0] nd [16];
  bit           fl [16];
  int           t;
  bit           m_inv;
  logic [W-1:0] exp_lane;
  bit           exp_clk, exp_doe, exp_coe;
  logic [15:0]  lfsr = 16'hACE1;
  string        seg_tag = "R1";

  function automatic logic [W-1:0] half_word(logic [W-1:0] s, bit lv, bit by, bit sec);
    logic [W-1:0] r;
    if (!lv) return s;
    r = '0;
    for (int k = 0; k < H; k++) begin
      if (by) r[k] = sec ? s[k + H] : s[k];
      else    r[k] = sec ? s[2*k + 1] : s[2*k];
    end
    return r;
  endfunction

  task automatic model_step();
    if (rst) begin
      for (int i = 0; i < 16; i++) begin nd[i] = '0; fl[i] = 1'b0; end
      t = 0; m_inv = 1'b0;
      exp_lane = '0; exp_clk = 1'b0; exp_doe = 1'b1; exp_coe = 1'b1;
    end else begin
      if (t % 2 == 0) begin
        nd[(t + 2) % 16] = half_word(sample_in, lvds_mode, byte_order, 1'b0);
        nd[(t + 3) % 16] = half_word(sample_in, lvds_mode, byte_order, 1'b1);
        fl[(t + 2) % 16] = data_delay;
        fl[(t + 3) % 16] = data_delay;
        m_inv   = clk_invert;
        exp_clk = ~clk_invert;
      end else begin
        exp_clk = m_inv;
      end
      exp_lane = fl[t % 16] ? nd[(t + 15) % 16] : nd[t % 16];
      exp_doe  = ~obuf_off;
      exp_coe  = ~(obuf_off | clkbuf_off);
      t++;
    end
  endtask

  task automatic compare();
    total++;
    if (lane_out !== exp_lane) begin
      bad++;
      $display("FAIL %s lanes: actual=%h expected=%h (edge %0d)", seg_tag, lane_out, exp_lane, t);
    end
    total++;
    if (clk_out !== exp_clk) begin
      bad++;
      $display("FAIL R7 clk_out: actual=%b expected=%b (edge %0d)", clk_out, exp_clk, t);
    end
    total++;
    if (data_oe !== exp_doe || clk_oe !== exp_coe) begin
      bad++;
      $display("FAIL %s enables: actual=%b%b expected=%b%b", rst ? "R1" : "R8",
               data_oe, clk_oe, exp_doe, exp_coe);
    end
  endtask

  task automatic next_rand();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
  endtask

  // one clock: judge the edge just passed, then drive for the next edge
  task automatic cycle(int seg);
    @(negedge clk);
    model_step();
    compare();
    next_rand();
    sample_in = lfsr[W-1:0];  // changes every edge; odd-edge values must be ignored (R2)
    case (seg)
      5: byte_order = ~byte_order;  // no effect in parallel mode (R5)
      7: begin  // every config bit may move on any edge (R9)
        lvds_mode  = lfsr[3];
        byte_order = lfsr[7];
        data_delay = lfsr[11];
        clk_invert = lfsr[14];
      end
      8: begin
        obuf_off   = lfsr[2];
        clkbuf_off = lfsr[9];
      end
      default: ;
    endcase
  endtask

  task automatic run_seg(int seg, int n, string tag, bit lv, bit by, bit dl, bit iv);
    @(negedge clk);
    model_step();
    compare();
    seg_tag    = tag;
    lvds_mode  = lv;
    byte_order = by;
    data_delay = dl;
    clk_invert = iv;
    obuf_off   = 1'b0;
    clkbuf_off = 1'b0;
    for (int i = 0; i < n; i++) cycle(seg);
  endtask

  initial begin
    #1_000_000;
    total++; bad++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst = 1'b1; sample_in = '0; lvds_mode = 1'b1; byte_order = 1'b0;
    data_delay = 1'b0; clk_invert = 1'b0; obuf_off = 1'b0; clkbuf_off = 1'b0;
    seg_tag = "R1";
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); model_step(); compare();
    end
    rst = 1'b0;
    run_seg(2, 40, "R3 R2", 1'b1, 1'b0, 1'b0, 1'b0);
    run_seg(3, 40, "R4 R2", 1'b1, 1'b1, 1'b0, 1'b0);
    run_seg(5, 40, "R5",    1'b0, 1'b0, 1'b0, 1'b0);
    run_seg(6, 40, "R6 R3", 1'b1, 1'b0, 1'b1, 1'b0);
    run_seg(9, 40, "R7 R4", 1'b1, 1'b1, 1'b0, 1'b1);
    run_seg(7, 120, "R9 R6", 1'b1, 1'b0, 1'b0, 1'b0);
    run_seg(8, 40, "R8 R3", 1'b1, 1'b0, 1'b0, 1'b0);
    // second reset in mid-stream: outputs back to reset values (R1)
    @(negedge clk); model_step(); compare();
    rst = 1'b1; seg_tag = "R1";
    for (int i = 0; i < 2; i++) begin
      @(negedge clk); model_step(); compare();
    end
    rst = 1'b0;
    run_seg(6, 40, "R6 R4", 1'b1, 1'b1, 1'b1, 1'b1);
    @(negedge clk); model_step(); compare();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule